// File: doc/BRIEF.md
# Microscaled Element Dequantizer

This block expands one stored microscaling block back into IEEE single-precision values. A block consists of an 8-bit shared scale and 32 narrow elements. The scale holds only a power of two and uses the same bit layout as the biased exponent of a 32-bit float. Each element is either a 4-bit float (1 sign, 2 exponent, 1 mantissa bit) or an 8-bit float (1 sign, 4 exponent, 3 mantissa bits). The format is chosen per block. The block takes a whole packed block in a single transfer. It then emits one decoded 32-bit float per cycle, and it raises a last flag on the 32nd value.

Each narrow element is first normalized, which includes its subnormal encodings. The shared scale is then applied by adding it to the element's exponent, so no multiplier is used. The output range stays correct at both ends: a reserved scale code forces NaN, a sum above the largest finite exponent saturates to a signed infinity, and a sum below the smallest normal exponent produces an FP32 subnormal.

Both sides use valid/ready. A block transfers on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only when no block is held, so the next block is taken only after the transfer flagged last has completed. On the output side, a held value waits as long as `out_ready` stays low. The downstream consumer can stall on any cycle without loss.

Top module: `mx_dequant`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` is 1 exactly when no block is held. A block is captured on a cycle with `in_valid` and `in_ready` both high. Its element 0 is presented with `out_valid` on the next cycle, and `in_ready` stays 0 until the last element has been transferred.
- R3: Elements leave in index order. With `in_fmt`=0 (4-bit elements), element i sits in `in_elems[4i+3:4i]` and bits 255:128 are ignored. With `in_fmt`=1 (8-bit elements), element i sits in `in_elems[8i+7:8i]`. `out_last` is 1 only on element 31, and `out_valid` drops on the cycle after that element is transferred.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_data`, `out_last` and the element index do not change.
- R5: A 4-bit element has its sign in bit 3, exponent field in bits 2:1 (bias 1) and mantissa in bit 0. An exponent field of 0 means the subnormal value m x 0.5.
- R6: An 8-bit element has its sign in bit 7, exponent field in bits 6:3 (bias 7) and mantissa in bits 2:0. An exponent field of 0 means the subnormal value m x 2^-9. Exponent field 15 with mantissa 7 is NaN and yields 0x7FC00000.
- R7: The result equals the element value times 2^(scale-127). A scale of 0xFF yields 0x7FC00000 for every element of the block.
- R8: An element whose value is zero yields a zero carrying the element's sign, for every scale except 0xFF.
- R9: If the biased FP32 exponent of the result would exceed 254, the output is infinity with the element's sign (0x7F800000 or 0xFF800000).
- R10: If the biased exponent would fall below 1, the output is an FP32 subnormal. Its mantissa is the significand shifted right, with shifted-out bits dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream offers a block |
| in_ready | output | 1 | Block register is empty |
| in_fmt | input | 1 | Element type: 0 = 4-bit E2M1, 1 = 8-bit E4M3 |
| in_scale | input | 8 | Shared power-of-two scale, biased by 127 |
| in_elems | input | 256 | Packed elements, element 0 in the least significant bits |
| out_valid | output | 1 | A decoded value is presented |
| out_ready | input | 1 | Downstream accepts the value |
| out_data | output | 32 | Decoded single-precision value |
| out_last | output | 1 | Marks element 31 of the block |

## Verification
A block is captured on the rising edge where `in_valid` and `in_ready` are both high. Its element 0 appears with `out_valid` right after that edge, with no added pipeline stage. Every later element appears right after the edge that completed the previous output transfer. The bench therefore drives and samples only on falling edges. It compares each presented value against a reference computed from the element's integer magnitude. While `out_ready` is held low, it checks that the same element is still presented. After the last transfer it checks on the next falling edge that `out_valid` has dropped and `in_ready` has risen.

// File: rtl/mxd_pkg.sv
package mxd_pkg;

  localparam int SCALE_W  = 8;
  localparam int FP_W     = 32;
  localparam int FP_EXP_W = 8;
  localparam int FP_MAN_W = 23;
  localparam int FRAC_W   = 3;   // widest narrow mantissa
  localparam int UEXP_W   = 6;   // signed unbiased exponent of a narrow element
  localparam int SUM_W    = 11;  // signed biased sum

  localparam logic [FP_W-1:0]     QNAN_BITS   = 32'h7FC0_0000;
  localparam logic [SCALE_W-1:0]  SCALE_NAN   = 8'hFF;
  localparam logic [FP_EXP_W-1:0] EXP_MAX_FIN = 8'hFE;

  typedef enum logic {
    FMT_E2M1 = 1'b0,
    FMT_E4M3 = 1'b1
  } elem_fmt_t;

  typedef struct packed {
    logic                     sign;
    logic                     zero;
    logic                     nan;
    logic signed [UEXP_W-1:0] uexp;  // value = 1.frac * 2^uexp
    logic [FRAC_W-1:0]        frac;
  } elem_norm_t;

endpackage

// File: rtl/mxd_expand.sv
module mxd_expand
  import mxd_pkg::*;
(
  input  elem_fmt_t  fmt,
  input  logic [7:0] code,
  output elem_norm_t norm
);

  logic [1:0] e2_exp;
  logic       e2_man;
  logic [3:0] e4_exp;
  logic [2:0] e4_man;

  assign e2_exp = code[2:1];
  assign e2_man = code[0];
  assign e4_exp = code[6:3];
  assign e4_man = code[2:0];

  always_comb begin
    norm = '0;
    if (fmt == FMT_E2M1) begin
      norm.sign = code[3];
      norm.zero = (e2_exp == 2'd0) && !e2_man;
      if (e2_exp == 2'd0) begin
        norm.uexp = -6'sd1;
        norm.frac = '0;
      end else begin
        norm.uexp = $signed({4'd0, e2_exp}) - 6'sd1;
        norm.frac = {e2_man, 2'b00};
      end
    end else begin
      norm.sign = code[7];
      norm.nan  = (e4_exp == 4'hF) && (e4_man == 3'h7);
      norm.zero = (e4_exp == 4'h0) && (e4_man == 3'h0);
      if (e4_exp == 4'h0) begin
        // subnormal: move leading one into the hidden position
        if (e4_man[2]) begin
          norm.uexp = -6'sd7;
          norm.frac = {e4_man[1:0], 1'b0};
        end else if (e4_man[1]) begin
          norm.uexp = -6'sd8;
          norm.frac = {e4_man[0], 2'b00};
        end else begin
          norm.uexp = -6'sd9;
          norm.frac = '0;
        end
      end else begin
        norm.uexp = $signed({2'd0, e4_exp}) - 6'sd7;
        norm.frac = e4_man;
      end
    end
  end

endmodule

// File: rtl/mxd_rescale.sv
module mxd_rescale
  import mxd_pkg::*;
(
  input  logic [SCALE_W-1:0] scale,
  input  elem_norm_t         norm,
  output logic [FP_W-1:0]    fp
);

  localparam int SIG_W = FP_MAN_W + 1;

  logic signed [SUM_W-1:0] biased;
  logic signed [SUM_W-1:0] shamt;
  logic [SIG_W-1:0]        sig;
  logic [SIG_W-1:0]        sub_sig;

  assign biased = $signed({{(SUM_W-SCALE_W){1'b0}}, scale})
                + {{(SUM_W-UEXP_W){norm.uexp[UEXP_W-1]}}, norm.uexp};
  assign shamt  = 11'sd1 - biased;
  assign sig    = {1'b1, norm.frac, {(FP_MAN_W-FRAC_W){1'b0}}};
  assign sub_sig = (shamt >= 11'sd24) ? '0 : (sig >> shamt[4:0]);

  always_comb begin
    if (scale == SCALE_NAN || norm.nan) begin
      fp = QNAN_BITS;
    end else if (norm.zero) begin
      fp = {norm.sign, {(FP_W-1){1'b0}}};
    end else if (biased > $signed({3'd0, EXP_MAX_FIN})) begin
      fp = {norm.sign, {FP_EXP_W{1'b1}}, {FP_MAN_W{1'b0}}};
    end else if (biased >= 11'sd1) begin
      fp = {norm.sign, biased[FP_EXP_W-1:0], norm.frac, {(FP_MAN_W-FRAC_W){1'b0}}};
    end else begin
      fp = {norm.sign, {FP_EXP_W{1'b0}}, sub_sig[FP_MAN_W-1:0]};
    end
  end

endmodule

// File: rtl/mx_dequant.sv
module mx_dequant
  import mxd_pkg::*;
#(
  parameter int NUM_ELEMS = 32,
  parameter int WIDE_W    = 8,
  parameter int NARROW_W  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic                        in_fmt,
  input  logic [SCALE_W-1:0]          in_scale,
  input  logic [NUM_ELEMS*WIDE_W-1:0] in_elems,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [FP_W-1:0]             out_data,
  output logic                        out_last
);

  localparam int BLK_W = NUM_ELEMS * WIDE_W;
  localparam int IDX_W = $clog2(NUM_ELEMS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_ELEMS - 1);

  logic               busy_q;
  logic [IDX_W-1:0]   idx_q;
  logic [BLK_W-1:0]   blk_q;
  elem_fmt_t          fmt_q;
  logic [SCALE_W-1:0] scale_q;

  logic [WIDE_W-1:0]  lane_code [NUM_ELEMS];
  logic [WIDE_W-1:0]  sel_code;
  elem_norm_t         norm;

  assign in_ready  = !busy_q;
  assign out_valid = busy_q;
  assign out_last  = busy_q && (idx_q == IDX_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (in_valid) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end
    end else if (out_ready) begin
      if (idx_q == IDX_LAST) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!busy_q && in_valid) begin
      blk_q   <= in_elems;
      fmt_q   <= elem_fmt_t'(in_fmt);
      scale_q <= in_scale;
    end
  end

  for (genvar g = 0; g < NUM_ELEMS; g++) begin : g_lane
    assign lane_code[g] = (fmt_q == FMT_E2M1)
      ? {{(WIDE_W-NARROW_W){1'b0}}, blk_q[g*NARROW_W +: NARROW_W]}
      : blk_q[g*WIDE_W +: WIDE_W];
  end

  assign sel_code = lane_code[idx_q];

  mxd_expand u_expand (
    .fmt  (fmt_q),
    .code (sel_code),
    .norm (norm)
  );

  mxd_rescale u_rescale (
    .scale (scale_q),
    .norm  (norm),
    .fp    (out_data)
  );

  AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R2
  AST_FIRST_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && !out_last); // R2
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R4
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid && in_ready); // R3
  AST_SCALE_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && scale_q == SCALE_NAN |-> out_data == QNAN_BITS); // R7
  AST_INF_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_data[30:23] == 8'hFF |-> out_data[22:0] == 23'd0 || out_data == QNAN_BITS); // R9

endmodule

// File: tb/mx_dequant_test.sv
module mx_dequant_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_fmt = 1'b0;
  logic [7:0]   in_scale = '0;
  logic [255:0] in_elems = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [31:0]  out_data;
  logic         out_last;

  int n_total = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  mx_dequant uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_fmt(in_fmt), .in_scale(in_scale), .in_elems(in_elems),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  // fmt, scale, code, expected value for every element of the block
  localparam logic [48:0] VEC [14] = '{
    {1'b0, 8'd127, 8'h07, 32'h40C0_0000},  // R5 max 6.0
    {1'b0, 8'd127, 8'h01, 32'h3F00_0000},  // R5 subnormal 0.5
    {1'b0, 8'd127, 8'h0F, 32'hC0C0_0000},  // R5 -6.0
    {1'b0, 8'd200, 8'h08, 32'h8000_0000},  // R8 negative zero
    {1'b0, 8'hFF,  8'h02, 32'h7FC0_0000},  // R7 NaN scale
    {1'b1, 8'd127, 8'h7E, 32'h43E0_0000},  // R6 max 448
    {1'b1, 8'd127, 8'h01, 32'h3B00_0000},  // R6 subnormal 2^-9
    {1'b1, 8'd127, 8'h7F, 32'h7FC0_0000},  // R6 element NaN
    {1'b1, 8'd254, 8'h7E, 32'h7F80_0000},  // R9 overflow
    {1'b1, 8'd246, 8'h78, 32'h7F00_0000},  // R9 top finite exponent
    {1'b1, 8'd0,   8'h01, 32'h0000_2000},  // R10 deep subnormal
    {1'b1, 8'd0,   8'h8F, 32'h8001_E000},  // R10 negative subnormal
    {1'b0, 8'd1,   8'h01, 32'h0040_0000},  // R10 biased zero
    {1'b1, 8'd3,   8'h06, 32'h0006_0000}   // R10 from element subnormal
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // reference: element magnitude as integer k times 2^off
  function automatic logic [31:0] ref_val(input logic fmt, input logic [7:0] scale, input logic [7:0] code);
    logic s;
    int e, m, k, off, p, eb, sh;
    logic [31:0] mant;
    if (fmt == 1'b0) begin
      s = code[3]; e = int'(code[2:1]); m = int'(code[0]); off = -1;
      k = (e == 0) ? m : ((2 + m) << (e - 1));
    end else begin
      s = code[7]; e = int'(code[6:3]); m = int'(code[2:0]); off = -9;
      if (e == 15 && m == 7) return 32'h7FC0_0000;
      k = (e == 0) ? m : ((8 + m) << (e - 1));
    end
    if (scale == 8'hFF) return 32'h7FC0_0000;
    if (k == 0) return {s, 31'd0};
    p = 0;
    for (int b = 0; b < 20; b++) if (k >= (1 << b)) p = b;
    eb = p + off + int'(scale);
    if (eb > 254) return {s, 8'hFF, 23'd0};
    if (eb >= 1) begin
      mant = (32'(k) << (23 - p)) & 32'h007F_FFFF;
      return {s, 8'(eb), mant[22:0]};
    end
    sh = off + int'(scale) + 22;
    mant = (sh >= 0) ? (32'(k) << sh) : (32'(k) >> (-sh));
    return {s, 8'd0, mant[22:0]};
  endfunction

  task automatic run_block(input logic fmt, input logic [7:0] scale, input logic [255:0] elems,
                           input bit use_exp, input logic [31:0] expv, input bit stall);
    int cyc = 0;
    @(negedge clk);
    check(in_ready == 1'b1, "R2 ready when idle", 32'(in_ready), 32'd1);
    in_valid = 1'b1; in_fmt = fmt; in_scale = scale; in_elems = elems;
    @(negedge clk);
    in_valid = 1'b0; in_elems = '1; in_scale = 8'hFF;
    check(out_valid == 1'b1, "R2 first element next cycle", 32'(out_valid), 32'd1);
    check(in_ready == 1'b0, "R2 ready low while held", 32'(in_ready), 32'd0);
    for (int i = 0; i < 32; ) begin
      bit r;
      logic [7:0] code;
      logic [31:0] want;
      r = !stall || (cyc % 3 == 2);
      cyc++;
      out_ready = r;
      code = fmt ? elems[8*i +: 8] : {4'd0, elems[4*i +: 4]};
      want = use_exp ? expv : ref_val(fmt, scale, code);
      check(out_valid == 1'b1, "R3 valid through block", 32'(out_valid), 32'd1);
      check(out_data == want, r ? "R3 R7 element value" : "R4 held while stalled", out_data, want);
      if (r) begin
        check(out_last == (i == 31), "R3 last flag", 32'(out_last), 32'(i == 31));
        i++;
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(out_valid == 1'b0, "R3 valid drops after last", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R2 ready after last", 32'(in_ready), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    logic [255:0] blk;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1 reset out_valid", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R1 reset in_ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;

    for (int v = 0; v < 14; v++) begin
      logic [48:0] t;
      t = VEC[v];
      blk = '0;
      for (int i = 0; i < 32; i++) begin
        if (t[48]) blk[8*i +: 8] = t[39:32];
        else       blk[4*i +: 4] = t[35:32];
      end
      if (!t[48]) blk[255:128] = {4{32'hDEAD_BEEF}};
      run_block(t[48], t[47:40], blk, 1'b1, t[31:0], v % 2 == 1);
    end

    // R3 R5: every 4-bit code, garbage in the ignored upper half
    blk = '0;
    for (int i = 0; i < 32; i++) blk[4*i +: 4] = 4'(i);
    blk[255:128] = {8{32'h5A3C_96F1}};
    run_block(1'b0, 8'd130, blk, 1'b0, '0, 1'b0);

    // R6 R9 R10: mixed 8-bit codes across scales
    for (int s = 0; s < 4; s++) begin
      logic [7:0] sc;
      sc = (s == 0) ? 8'd0 : (s == 1) ? 8'd127 : (s == 2) ? 8'd250 : 8'd5;
      for (int i = 0; i < 32; i++) blk[8*i +: 8] = 8'(i * 37 + s * 11 + 3);
      run_block(1'b1, sc, blk, 1'b0, '0, s % 2 == 0);
    end

    // R7: reserved scale across all 8-bit codes incl. zero
    for (int i = 0; i < 32; i++) blk[8*i +: 8] = 8'(i * 8);
    run_block(1'b1, 8'hFF, blk, 1'b0, '0, 1'b0);

    // R1: reset while a block is held
    @(negedge clk);
    in_valid = 1'b1; in_fmt = 1'b1; in_scale = 8'd127; in_elems = blk;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 reset clears held block", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R1 reset ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule